// File: doc/BRIEF.md
# Interrupt Priority and In-Service Tracker

This block keeps per-vector interrupt state for one processor. Each of the vectors has a pending bit, an in-service bit and a trigger-mode bit. Accepted interrupts arrive on a delivery port that carries a vector number and a level/edge flag. The block holds an 8-bit task priority and derives the processor priority and the arbitration priority from it. It offers the best eligible pending vector to the core, and an acknowledge moves that vector from pending to in-service. An end-of-interrupt strobe retires the highest in-service vector. If the retired vector was level-triggered, the block emits a one-cycle broadcast pulse that carries the vector number, so that upstream interrupt sources can re-arm.

A vector's class is its upper nibble. A pending vector goes to the core only when its class is above the class of the processor priority. Requests that priority holds back stay pending and are offered later, once the task priority is lowered or in-service vectors retire.

Top module: `irq_prio_tracker`

## Requirements
- R1: A delivery of any vector below 16 is ignored, and bits 0 to 15 of the pending, in-service and trigger-mode vectors always read 0.
- R2: A delivery of vector v (v >= 16) sets pending bit v at the next clock edge. A second delivery of a vector that is already pending merges into the same bit, so a single acknowledge clears it.
- R3: On every accepted delivery, trigger-mode bit v takes the delivery's level flag (1 = level, 0 = edge) at the same edge that sets the pending bit.
- R4: Processor priority equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector (0 if none). Otherwise it equals that in-service class in bits 7:4, with bits 3:0 zero.
- R5: Arbitration priority equals the task priority when the task class is at least the highest pending class and strictly above the highest in-service class (each 0 if empty). Otherwise bits 7:4 hold max(task class AND in-service class, pending class) and bits 3:0 are zero.
- R6: int_req_o is 1 only when the highest-numbered pending vector has a class strictly above the processor priority class. int_vec_o is that vector. Both follow the current state in the same cycle. A task class of 15 blocks every request.
- R7: An acknowledge while int_req_o is 1 clears the offered pending bit and sets the matching in-service bit at the next edge. An acknowledge while int_req_o is 0 changes nothing.
- R8: An end-of-interrupt strobe clears the highest-numbered in-service bit at the next edge. With no in-service bit set, it changes nothing.
- R9: When the retired vector's trigger-mode bit is 1, eoi_bcast_o is 1 for exactly the one cycle after that edge, with eoi_bcast_vec_o equal to the vector. In every other case it stays 0.
- R10: A request held back by priority stays pending and is offered once the task priority drops below its class.
- R11: After reset, all state vectors, the task priority, int_req_o and eoi_bcast_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dlv_valid_i | input | 1 | Accepted interrupt delivery strobe |
| dlv_vec_i | input | 8 | Delivered vector number |
| dlv_level_i | input | 1 | 1 = level-triggered, 0 = edge |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 8 | Task priority write value |
| ack_i | input | 1 | Core acknowledge of the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe (no data) |
| int_req_o | output | 1 | Eligible interrupt offered |
| int_vec_o | output | 8 | Offered vector |
| tpr_o | output | 8 | Task priority |
| ppr_o | output | 8 | Processor priority |
| apr_o | output | 8 | Arbitration priority |
| irr_o | output | 256 | Pending vector bits |
| isr_o | output | 256 | In-service vector bits |
| tmr_o | output | 256 | Trigger-mode bits |
| eoi_bcast_o | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
Deliveries, acknowledges, task-priority writes and end-of-interrupt strobes change the state vectors at the first rising edge after they are driven. The priorities, int_req_o and int_vec_o are combinational from that state, so they are due in the same cycle. The broadcast pulse is registered at that same edge, so it is visible in the cycle right after the strobe and gone one cycle later. The bench drives inputs at the falling edge, updates its model on the rising edge, and compares every output 1 ns after that edge, which lines each check up with that single-edge latency.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned CLS_W  = 4;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [CLS_W-1:0]  cls_t;
endpackage

// File: rtl/ipt_hi_find.sv
module ipt_hi_find #(
  parameter int unsigned W  = 256,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ipt_vec_bank.sv
module ipt_vec_bank #(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned NUM_RSVD = 16,
  parameter int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [VEC_W-1:0]   set_vec_i,
  input  logic               set_level_i,
  input  logic               ack_en_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  input  logic               eoi_en_i,
  input  logic [VEC_W-1:0]   eoi_vec_i,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    if (g < NUM_RSVD) begin : g_rsvd
      assign irr_o[g] = 1'b0;
      assign isr_o[g] = 1'b0;
      assign tmr_o[g] = 1'b0;
    end else begin : g_live
      logic irr_r, isr_r, tmr_r;
      logic hit_set, hit_ack, hit_eoi;
      assign hit_set = set_en_i && (set_vec_i == VEC_W'(g));
      assign hit_ack = ack_en_i && (ack_vec_i == VEC_W'(g));
      assign hit_eoi = eoi_en_i && (eoi_vec_i == VEC_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          irr_r <= 1'b0;
          isr_r <= 1'b0;
          tmr_r <= 1'b0;
        end else begin
          // new delivery wins over a same-cycle acknowledge of the same vector
          if (hit_set)      irr_r <= 1'b1;
          else if (hit_ack) irr_r <= 1'b0;
          if (hit_ack)      isr_r <= 1'b1;
          else if (hit_eoi) isr_r <= 1'b0;
          if (hit_set)      tmr_r <= set_level_i;
        end
      end
      assign irr_o[g] = irr_r;
      assign isr_o[g] = isr_r;
      assign tmr_o[g] = tmr_r;
    end
  end
endmodule

// File: rtl/ipt_prio_calc.sv
module ipt_prio_calc
  import ipt_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  prio_t             tpr_i,
  input  logic              irr_any_i,
  input  logic [VEC_W-1:0]  irr_top_i,
  input  logic              isr_any_i,
  input  logic [VEC_W-1:0]  isr_top_i,
  output prio_t             ppr_o,
  output prio_t             apr_o,
  output logic              int_req_o,
  output logic [VEC_W-1:0]  int_vec_o
);
  cls_t tpr_cls, isr_cls, irr_cls, apr_hi, and_cls;

  assign tpr_cls = tpr_i[PRIO_W-1 -: CLS_W];
  assign isr_cls = isr_any_i ? isr_top_i[VEC_W-1 -: CLS_W] : '0;
  assign irr_cls = irr_any_i ? irr_top_i[VEC_W-1 -: CLS_W] : '0;
  assign and_cls = tpr_cls & isr_cls;
  assign apr_hi  = (and_cls > irr_cls) ? and_cls : irr_cls;

  always_comb begin
    if (tpr_cls >= isr_cls) ppr_o = tpr_i;
    else                    ppr_o = {isr_cls, {(PRIO_W-CLS_W){1'b0}}};
    if (tpr_cls >= irr_cls && tpr_cls > isr_cls) apr_o = tpr_i;
    else                                        apr_o = {apr_hi, {(PRIO_W-CLS_W){1'b0}}};
  end

  // highest pending has the highest class; if it is blocked, all are
  assign int_req_o = irr_any_i && (irr_cls > ppr_o[PRIO_W-1 -: CLS_W]);
  assign int_vec_o = irr_top_i;
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import ipt_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned NUM_RSVD = 16,
  localparam int unsigned VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dlv_valid_i,
  input  logic [VEC_W-1:0]   dlv_vec_i,
  input  logic               dlv_level_i,
  input  logic               tpr_we_i,
  input  logic [7:0]         tpr_wdata_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               int_req_o,
  output logic [VEC_W-1:0]   int_vec_o,
  output logic [7:0]         tpr_o,
  output logic [7:0]         ppr_o,
  output logic [7:0]         apr_o,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o,
  output logic               eoi_bcast_o,
  output logic [VEC_W-1:0]   eoi_bcast_vec_o
);
  prio_t            tpr_q;
  logic             irr_any, isr_any;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic             dlv_ok, ack_fire, eoi_fire;
  logic             bc_q;
  logic [VEC_W-1:0] bc_vec_q;

  assign dlv_ok   = dlv_valid_i && (dlv_vec_i >= VEC_W'(NUM_RSVD));
  assign ack_fire = ack_i && int_req_o;
  assign eoi_fire = eoi_i && isr_any;

  ipt_vec_bank #(.NUM_VEC(NUM_VEC), .NUM_RSVD(NUM_RSVD), .VEC_W(VEC_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (dlv_ok),
    .set_vec_i  (dlv_vec_i),
    .set_level_i(dlv_level_i),
    .ack_en_i   (ack_fire),
    .ack_vec_i  (int_vec_o),
    .eoi_en_i   (eoi_fire),
    .eoi_vec_i  (isr_top),
    .irr_o      (irr_o),
    .isr_o      (isr_o),
    .tmr_o      (tmr_o)
  );

  ipt_hi_find #(.W(NUM_VEC), .IW(VEC_W)) u_irr_find (
    .vec_i(irr_o), .any_o(irr_any), .idx_o(irr_top)
  );
  ipt_hi_find #(.W(NUM_VEC), .IW(VEC_W)) u_isr_find (
    .vec_i(isr_o), .any_o(isr_any), .idx_o(isr_top)
  );

  ipt_prio_calc #(.VEC_W(VEC_W)) u_calc (
    .tpr_i    (tpr_q),
    .irr_any_i(irr_any),
    .irr_top_i(irr_top),
    .isr_any_i(isr_any),
    .isr_top_i(isr_top),
    .ppr_o    (ppr_o),
    .apr_o    (apr_o),
    .int_req_o(int_req_o),
    .int_vec_o(int_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q    <= '0;
      bc_q     <= 1'b0;
      bc_vec_q <= '0;
    end else begin
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      bc_q <= eoi_fire && tmr_o[isr_top];
      if (eoi_fire) bc_vec_q <= isr_top;
    end
  end

  assign tpr_o           = tpr_q;
  assign eoi_bcast_o     = bc_q;
  assign eoi_bcast_vec_o = bc_vec_q;
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned NUM_RSVD = 16,
  parameter int unsigned VEC_W    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dlv_valid_i,
  input logic [VEC_W-1:0]   dlv_vec_i,
  input logic               dlv_level_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               int_req_o,
  input logic [VEC_W-1:0]   int_vec_o,
  input logic [7:0]         tpr_o,
  input logic [7:0]         ppr_o,
  input logic [NUM_VEC-1:0] irr_o,
  input logic [NUM_VEC-1:0] isr_o,
  input logic [NUM_VEC-1:0] tmr_o,
  input logic               eoi_bcast_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_o[NUM_RSVD-1:0] | isr_o[NUM_RSVD-1:0] | tmr_o[NUM_RSVD-1:0]) == '0); // R1

  AST_DLV_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && dlv_vec_i >= VEC_W'(NUM_RSVD)) |=> irr_o[$past(dlv_vec_i)]); // R2

  AST_TMR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && dlv_vec_i >= VEC_W'(NUM_RSVD)) |=> tmr_o[$past(dlv_vec_i)] == $past(dlv_level_i)); // R3

  AST_PPR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[7:4] >= tpr_o[7:4]); // R4

  AST_REQ_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o |-> (int_vec_o[VEC_W-1:VEC_W-4] > ppr_o[7:4]) && irr_o[int_vec_o]); // R6

  AST_TPR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpr_o[7:4] == 4'hF) |-> !int_req_o); // R6

  AST_ACK_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_req_o) |=> isr_o[$past(int_vec_o)]); // R7

  AST_BCAST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i)); // R9

  AST_BCAST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_bcast_o && !eoi_i) |=> !eoi_bcast_o); // R9
endmodule

bind irq_prio_tracker ipt_checker #(.NUM_VEC(NUM_VEC), .NUM_RSVD(NUM_RSVD), .VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dlv_valid_i(dlv_valid_i), .dlv_vec_i(dlv_vec_i),
  .dlv_level_i(dlv_level_i), .ack_i(ack_i), .eoi_i(eoi_i), .int_req_o(int_req_o),
  .int_vec_o(int_vec_o), .tpr_o(tpr_o), .ppr_o(ppr_o), .irr_o(irr_o), .isr_o(isr_o),
  .tmr_o(tmr_o), .eoi_bcast_o(eoi_bcast_o)
);

// File: tb/sim_irq_prio_tracker.sv
`timescale 1ns/1ps
module sim_irq_prio_tracker;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         dlv_valid = 1'b0;
  logic [7:0]   dlv_vec = '0;
  logic         dlv_level = 1'b0;
  logic         tpr_we = 1'b0;
  logic [7:0]   tpr_wdata = '0;
  logic         ack = 1'b0;
  logic         eoi = 1'b0;
  logic         int_req;
  logic [7:0]   int_vec, tpr, ppr, apr, bc_vec;
  logic [255:0] irr, isr, tmr;
  logic         bc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [7:0]   m_tpr = '0;
  logic         m_bc = 1'b0;
  logic [7:0]   m_bc_vec = '0;

  always #2 clk = ~clk;

  irq_prio_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dlv_valid_i(dlv_valid), .dlv_vec_i(dlv_vec),
    .dlv_level_i(dlv_level), .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata), .ack_i(ack),
    .eoi_i(eoi), .int_req_o(int_req), .int_vec_o(int_vec), .tpr_o(tpr), .ppr_o(ppr),
    .apr_o(apr), .irr_o(irr), .isr_o(isr), .tmr_o(tmr), .eoi_bcast_o(bc),
    .eoi_bcast_vec_o(bc_vec)
  );

  function automatic int top_of(logic [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int cls_of(int v);
    return (v < 0) ? 0 : (v >> 4);
  endfunction

  function automatic logic [7:0] exp_ppr();
    int tc = m_tpr[7:4];
    int ic = cls_of(top_of(m_isr));
    if (tc >= ic) return m_tpr;
    return 8'(ic << 4);
  endfunction

  function automatic logic [7:0] exp_apr();
    int tc = m_tpr[7:4];
    int ic = cls_of(top_of(m_isr));
    int rc = cls_of(top_of(m_irr));
    int a  = tc & ic;
    if (tc >= rc && tc > ic) return m_tpr;
    return 8'(((a > rc) ? a : rc) << 4);
  endfunction

  function automatic bit exp_req();
    int t = top_of(m_irr);
    return (t >= 0) && ((t >> 4) > int'(exp_ppr() >> 4));
  endfunction

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1", "reserved bits", {240'b0, irr[15:0] | isr[15:0] | tmr[15:0]}, '0);
    chk("R2", "irr", irr, m_irr);
    chk("R3", "tmr", tmr, m_tmr);
    chk("R4", "ppr", {248'b0, ppr}, {248'b0, exp_ppr()});
    chk("R5", "apr", {248'b0, apr}, {248'b0, exp_apr()});
    chk("R6", "int_req", {255'b0, int_req}, {255'b0, exp_req()});
    if (exp_req()) chk("R6", "int_vec", {248'b0, int_vec}, 256'(top_of(m_irr)));
    chk("R7_R8", "isr", isr, m_isr);
    chk("R9", "bcast", {255'b0, bc}, {255'b0, m_bc});
    if (m_bc) chk("R9", "bcast vec", {248'b0, bc_vec}, {248'b0, m_bc_vec});
  endtask

  task automatic step(bit dv, int v, bit lvl, bit tw, int tval, bit a, bit e);
    bit   do_ack;
    int   av, et;
    @(negedge clk);
    dlv_valid = dv; dlv_vec = 8'(v); dlv_level = lvl;
    tpr_we = tw; tpr_wdata = 8'(tval); ack = a; eoi = e;
    do_ack = a && exp_req();
    av = top_of(m_irr);
    et = top_of(m_isr);
    @(posedge clk);
    #1;
    m_bc = 1'b0;
    if (e && et >= 0) begin
      m_bc = m_tmr[et];
      m_bc_vec = 8'(et);
      m_isr[et] = 1'b0;
    end
    if (do_ack) begin
      m_irr[av] = 1'b0;
      m_isr[av] = 1'b1;
    end
    if (dv && v >= 16) begin
      m_irr[v] = 1'b1;
      m_tmr[v] = lvl;
    end
    if (tw) m_tpr = 8'(tval);
    dlv_valid = 0; tpr_we = 0; ack = 0; eoi = 0;
    compare_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R11 reset state
    chk("R11", "reset irr|isr|tmr", irr | isr | tmr, '0);
    chk("R11", "reset tpr/req/bcast", {246'b0, tpr, int_req, bc}, '0);

    // R1 reserved vector dropped
    step(1, 5, 1, 0, 0, 0, 0);
    chk("R1", "vector 5 ignored", {255'b0, irr[5]}, '0);
    // R2 merge of duplicate deliveries, R3 level flag
    step(1, 'h41, 0, 0, 0, 0, 0);
    step(1, 'h41, 1, 0, 0, 0, 0);
    chk("R3", "tmr 0x41 level", {255'b0, tmr[8'h41]}, 256'd1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R2", "merged request gone after one ack", {255'b0, int_req}, '0);
    // R9 level retire produces pulse, then drops
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9", "pulse on level eoi", {247'b0, bc, bc_vec}, {247'b0, 1'b1, 8'h41});
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "pulse one cycle", {255'b0, bc}, '0);
    // R8 eoi with nothing in service
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8", "empty eoi no effect", isr, '0);
    // R6 class 15 blocks, R7 ack ignored without request
    step(0, 0, 0, 1, 'hF0, 0, 0);
    step(1, 'hE5, 0, 0, 0, 0, 0);
    chk("R6", "class 15 blocks", {255'b0, int_req}, '0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R7", "ack without request ignored", {255'b0, irr[8'hE5], isr[8'hE5]}, 256'b10);
    // R10 lowered priority releases held request
    step(0, 0, 0, 1, 'h30, 0, 0);
    chk("R10", "held request offered", {247'b0, int_req, int_vec}, {247'b0, 1'b1, 8'hE5});
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 'h52, 0, 0, 0, 0, 0);
    chk("R4", "ppr from in-service class", {248'b0, ppr}, 256'hE0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R10", "0x52 offered after retire", {247'b0, int_req, int_vec}, {247'b0, 1'b1, 8'h52});
    chk("R9", "edge eoi no pulse", {255'b0, bc}, '0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit dv  = ($urandom % 2) == 0;
      int v   = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 256);
      bit lv  = $urandom % 2;
      bit tw  = ($urandom % 12) == 0;
      int tv  = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 64);
      bit a   = ($urandom % 3) == 0;
      bit e   = ($urandom % 4) == 0;
      step(dv, v, lv, tw, tv, a, e);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule